// File: doc/BRIEF.md
# PCI Configuration and I/O Access Port

This block sits on the bridge side of a host-to-PCI path. It receives single register accesses from the CPU and turns them into configuration or I/O cycles on a request interface toward the bus engine. It has three windows. The first is a 32-bit address register, which selects the configuration target and also serves as the base address for I/O. The second is a configuration data window, which issues configuration reads and writes. The third is a 4-byte I/O data window, which issues byte, halfword or word I/O cycles.

The CPU side has one access in flight at a time, and `cpu_ready` tells the CPU when an access is accepted. Accesses to the address register complete in the cycle after they are accepted. Window accesses first place a request on the downstream valid/ready interface. A write completes after the downstream handshake. A read completes only after the read data has come back. If the combination of size and byte offset is illegal, the block answers with an error and sends nothing downstream.

The local address `cpu_addr[3:2]` selects the window: 0 is the address register, 1 is configuration data, 2 is I/O data, and 3 is unmapped. `cpu_addr[1:0]` is the byte offset `k`. Size codes are: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved.

Top module: `pci_cfgio_port`

## Requirements
- R1: A legal write to the address register stores all 32 bits of `cpu_wdata`. A read of the address register returns that full value, including bits 1:0.
- R2: The address register accepts only size code 2 at offset 0. Any other access to it returns `rsp_err`=1 and leaves the stored value unchanged.
- R3: A configuration data access at offset k drives `dn_io`=0, `dn_big_endian`=0 and `dn_addr` = {stored[31:2], k}. Bit 31 of the stored value does not gate the cycle.
- R4: An I/O data access at offset k drives `dn_io`=1, `dn_big_endian`=1 and `dn_addr` = zero-extended 16-bit sum ({stored[31:2],2'b00} + k).
- R5: In both data windows, offset 0 takes size codes 0, 1 and 2. Offset 2 takes codes 0 and 1. Offsets 1 and 3 take only code 0. Code 3 is never legal. A legal access drives `dn_size` equal to `cpu_size` and `dn_write`/`dn_wdata` from the CPU access.
- R6: An illegal access gives `rsp_valid` with `rsp_err`=1 and `rsp_rdata`=0 one cycle after acceptance. It issues no downstream request.
- R7: While `dn_valid` is high and `dn_ready` is low, the request stays unchanged and `cpu_ready` stays low.
- R8: A window write returns `rsp_valid` with `rsp_err`=0 and `rsp_rdata`=0 one cycle after the downstream handshake. An address register write answers one cycle after acceptance.
- R9: A window read returns `rsp_valid` one cycle after `dn_rvalid`, with `rsp_rdata` equal to `dn_rdata` and `rsp_err`=0.
- R10: After reset the stored address is 0, `dn_valid` and `rsp_valid` are low, and `cpu_ready` is high.
- R11: An access to the unmapped window (`cpu_addr[3:2]`=3) is illegal and is handled as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Access accepted this cycle when cpu_valid is high |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Window select [3:2] and byte offset [1:0] |
| cpu_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| cpu_wdata | input | 32 | CPU write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Downstream cycle request |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_io | output | 1 | 1 = I/O cycle, 0 = configuration cycle |
| dn_write | output | 1 | Cycle direction |
| dn_addr | output | 32 | Cycle address |
| dn_size | output | 2 | Cycle size code |
| dn_wdata | output | 32 | Cycle write data |
| dn_big_endian | output | 1 | Byte order of the data lanes |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The collision of interest is a second CPU access that arrives while the downstream request is stalled. The bench makes the stall happen by holding `dn_ready` low for several cycles after an I/O write is presented. At the same time it keeps a following I/O read asserted on `cpu_valid`. On every stalled cycle the bench checks that `cpu_ready` is low and that the request it is holding has not changed. It then checks that the pending read is issued only after the write has completed, and that both responses arrive in order with the expected addresses and data.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    localparam int DW  = 32;
    localparam int LAW = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        WIN_ADDR = 2'd0,
        WIN_CFG  = 2'd1,
        WIN_IO   = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             io;
        logic             write;
        logic [DW-1:0]    addr;
        xfer_size_e       size;
        logic [DW-1:0]    wdata;
        logic             big_endian;
    } dn_req_t;

    // Natural alignment rule inside a 4-byte data window
    function automatic logic size_fits(input logic [1:0] off, input xfer_size_e sz);
        logic ok;
        case (sz)
            SZ_BYTE: ok = 1'b1;
            SZ_HALF: ok = (off[0] == 1'b0);
            SZ_WORD: ok = (off == 2'd0);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/pcp_decode.sv
module pcp_decode
    import pcp_pkg::*;
#(
    parameter int IO_ADDR_W = 16
) (
    input  logic [LAW-1:0] addr,
    input  xfer_size_e     size,
    input  logic [DW-1:0]  base,
    output win_e           win,
    output logic           legal,
    output logic [DW-1:0]  target
);
    localparam int OFF_W = 2;

    logic [OFF_W-1:0]     off;
    logic [IO_ADDR_W-1:0] io_sum;

    assign off    = addr[OFF_W-1:0];
    assign win    = win_e'(addr[LAW-1:LAW-2]);
    assign io_sum = base[IO_ADDR_W-1:0] + {{(IO_ADDR_W-OFF_W){1'b0}}, off};

    always_comb begin
        legal  = 1'b0;
        target = '0;
        case (win)
            WIN_ADDR: legal = (size == SZ_WORD) && (off == '0);
            WIN_CFG: begin
                legal  = size_fits(off, size);
                target = {base[DW-1:OFF_W], off};
            end
            WIN_IO: begin
                legal  = size_fits(off, size);
                target = {{(DW-IO_ADDR_W){1'b0}}, io_sum};
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcp_addr_reg.sv
module pcp_addr_reg
    import pcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] full_q,
    output logic [DW-1:0] fwd
);
    always_ff @(posedge clk) begin
        if (rst)        full_q <= '0;
        else if (wr_en) full_q <= wdata;
    end

    assign fwd = {full_q[DW-1:2], 2'b00};

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(full_q)); // R2
endmodule

// File: rtl/pcp_seq.sv
module pcp_seq
    import pcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          legal,
    input  win_e          win,
    input  logic          write,
    input  logic [DW-1:0] target,
    input  xfer_size_e    size,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] reg_rdata,
    input  logic          dn_ready,
    input  logic          dn_rvalid,
    input  logic [DW-1:0] dn_rdata,
    output logic          idle,
    output logic          dn_valid,
    output dn_req_t       dn_req,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata
);
    seq_state_e state;

    assign idle     = (state == ST_IDLE);
    assign dn_valid = (state == ST_ISSUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dn_req    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (!legal) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '0;
                    end else if (win == WIN_ADDR) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_rdata <= write ? '0 : reg_rdata;
                    end else begin
                        dn_req.io         <= (win == WIN_IO);
                        dn_req.write      <= write;
                        dn_req.addr       <= target;
                        dn_req.size       <= size;
                        dn_req.wdata      <= wdata;
                        dn_req.big_endian <= (win == WIN_IO);
                        state             <= ST_ISSUE;
                    end
                end
                ST_ISSUE: if (dn_ready) begin
                    if (dn_req.write) begin
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_rdata <= '0;
                        state     <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (dn_rvalid) begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= 1'b0;
                    rsp_rdata <= dn_rdata;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_req))); // R7
    AST_READ_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && dn_rvalid) |=> (rsp_valid && !rsp_err)); // R9
    AST_WRITE_DONE: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_ready && dn_req.write) |=> (rsp_valid && !rsp_err)); // R8
endmodule

// File: rtl/pci_cfgio_port.sv
module pci_cfgio_port
    import pcp_pkg::*;
#(
    parameter int IO_ADDR_W = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    output logic          cpu_ready,
    input  logic          cpu_write,
    input  logic [3:0]    cpu_addr,
    input  logic [1:0]    cpu_size,
    input  logic [31:0]   cpu_wdata,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [31:0]   rsp_rdata,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic          dn_io,
    output logic          dn_write,
    output logic [31:0]   dn_addr,
    output logic [1:0]    dn_size,
    output logic [31:0]   dn_wdata,
    output logic          dn_big_endian,
    input  logic          dn_rvalid,
    input  logic [31:0]   dn_rdata
);
    win_e          win;
    logic          legal;
    logic [DW-1:0] target;
    logic [DW-1:0] full_q;
    logic [DW-1:0] fwd;
    logic          idle;
    logic          accept;
    logic          reg_wr;
    dn_req_t       req;

    assign accept    = cpu_valid && idle;
    assign cpu_ready = idle;
    assign reg_wr    = accept && cpu_write && legal && (win == WIN_ADDR);

    pcp_decode #(.IO_ADDR_W(IO_ADDR_W)) u_dec (
        .addr   (cpu_addr),
        .size   (xfer_size_e'(cpu_size)),
        .base   (fwd),
        .win    (win),
        .legal  (legal),
        .target (target)
    );

    pcp_addr_reg u_areg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .wdata  (cpu_wdata),
        .full_q (full_q),
        .fwd    (fwd)
    );

    pcp_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .legal     (legal),
        .win       (win),
        .write     (cpu_write),
        .target    (target),
        .size      (xfer_size_e'(cpu_size)),
        .wdata     (cpu_wdata),
        .reg_rdata (full_q),
        .dn_ready  (dn_ready),
        .dn_rvalid (dn_rvalid),
        .dn_rdata  (dn_rdata),
        .idle      (idle),
        .dn_valid  (dn_valid),
        .dn_req    (req),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    assign dn_io         = req.io;
    assign dn_write      = req.write;
    assign dn_addr       = req.addr;
    assign dn_size       = req.size;
    assign dn_wdata      = req.wdata;
    assign dn_big_endian = req.big_endian;

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (accept && !legal) |=> (!dn_valid && rsp_valid && rsp_err)); // R6
    AST_IO_RANGE: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_io) |-> (dn_addr[31:IO_ADDR_W] == '0 && dn_big_endian)); // R4
    AST_CFG_LOW: assert property (@(posedge clk) disable iff (rst)
        (accept && legal && win == WIN_CFG) |=> (dn_addr[1:0] == $past(cpu_addr[1:0]) && !dn_big_endian)); // R3
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !cpu_ready); // R7
endmodule

// File: tb/sim_pci_cfgio_port.sv
module sim_pci_cfgio_port;
    typedef struct packed {
        logic        io;
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        be;
    } exp_dn_t;

    typedef struct packed {
        logic        err;
        logic [31:0] data;
        logic [3:0]  tag;
    } exp_rsp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic        cpu_write = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dn_valid, dn_io, dn_write, dn_big_endian;
    logic [31:0] dn_addr, dn_wdata;
    logic [1:0]  dn_size;
    logic        dn_ready = 1'b0;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = '0;

    int checks = 0;
    int errors = 0;
    int stall  = 0;
    logic [31:0] mdl_addr = '0;
    exp_dn_t  q_dn[$];
    exp_rsp_t q_rsp[$];

    always #2.5 clk = ~clk;

    pci_cfgio_port u0 (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_io(dn_io), .dn_write(dn_write), .dn_addr(dn_addr), .dn_size(dn_size),
        .dn_wdata(dn_wdata), .dn_big_endian(dn_big_endian),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: holds the access until it is accepted
    task automatic cpu_op(input logic [3:0] a, input logic wr, input logic [1:0] sz, input logic [31:0] wd);
        bit acc;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        forever begin
            acc = cpu_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic reg_wr(input logic [31:0] v, input logic [3:0] tag);
        q_rsp.push_back('{err: 1'b0, data: 32'h0, tag: tag});
        mdl_addr = v;
        cpu_op(4'h0, 1'b1, 2'd2, v);
    endtask

    task automatic reg_rd(input logic [3:0] tag);
        q_rsp.push_back('{err: 1'b0, data: mdl_addr, tag: tag});
        cpu_op(4'h0, 1'b0, 2'd2, 32'h0);
    endtask

    task automatic bad_op(input logic [3:0] a, input logic wr, input logic [1:0] sz, input logic [3:0] tag);
        q_rsp.push_back('{err: 1'b1, data: 32'h0, tag: tag});
        cpu_op(a, wr, sz, 32'hDEAD_BEEF);
    endtask

    task automatic win_op(input bit io, input logic [1:0] off, input logic wr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [3:0] tag);
        logic [31:0] tgt;
        logic [15:0] s16;
        if (io) begin
            s16 = mdl_addr[15:0] & 16'hFFFC;
            s16 = s16 + {14'h0, off};
            tgt = {16'h0, s16};
        end else begin
            tgt = {mdl_addr[31:2], off};
        end
        q_dn.push_back('{io: io, wr: wr, addr: tgt, size: sz, wdata: wd, be: io});
        q_rsp.push_back('{err: 1'b0, data: wr ? 32'h0 : pattern(tgt), tag: tag});
        cpu_op({io ? 2'd2 : 2'd1, off}, wr, sz, wd);
    endtask

    // scoreboard monitor for responses
    initial begin
        exp_rsp_t e;
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (q_rsp.size() == 0) begin
                    check(1'b0, "R6 unexpected response", 64'(rsp_err), 64'h0);
                end else begin
                    e = q_rsp.pop_front();
                    check(rsp_err == e.err && rsp_rdata == e.data,
                          $sformatf("R%0d response", e.tag), {31'h0, rsp_err, rsp_rdata}, {31'h0, e.err, e.data});
                end
            end
        end
    end

    // downstream responder and request checker
    initial begin
        exp_dn_t e;
        exp_dn_t got;
        forever begin
            @(negedge clk);
            dn_ready = 1'b0; dn_rvalid = 1'b0;
            if (!rst && dn_valid) begin
                got = '{io: dn_io, wr: dn_write, addr: dn_addr, size: dn_size, wdata: dn_wdata, be: dn_big_endian};
                if (q_dn.size() == 0) begin
                    check(1'b0, "R6 unexpected downstream cycle", 64'(dn_addr), 64'h0);
                    e = got;
                end else begin
                    e = q_dn.pop_front();
                    check(got == e, e.io ? "R4/R5 io request" : "R3/R5 cfg request", 64'(got), 64'(e));
                end
                for (int i = 0; i < stall; i++) begin
                    @(negedge clk);
                    got = '{io: dn_io, wr: dn_write, addr: dn_addr, size: dn_size, wdata: dn_wdata, be: dn_big_endian};
                    check(dn_valid && !cpu_ready && got == e, "R7 stalled request held",
                          {30'h0, dn_valid, cpu_ready, 32'(got.addr)}, {30'h0, 1'b1, 1'b0, 32'(e.addr)});
                end
                dn_ready = 1'b1;
                @(negedge clk);
                dn_ready = 1'b0;
                if (!e.wr) begin
                    dn_rdata  = pattern(e.addr);
                    dn_rvalid = 1'b1;
                    @(negedge clk);
                    dn_rvalid = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 64'h0, 64'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(cpu_ready && !dn_valid && !rsp_valid, "R10 reset outputs",
              {61'h0, cpu_ready, dn_valid, rsp_valid}, 64'h4);
        reg_rd(4'd10);

        // R1 full readback including low bits
        reg_wr(32'h8012_3457, 4'd1);
        reg_rd(4'd1);

        // R2 wrong size / offset on address register
        bad_op(4'h0, 1'b1, 2'd1, 4'd2);
        bad_op(4'h1, 1'b1, 2'd2, 4'd2);
        reg_rd(4'd2);

        // R3 config cycles, top bit set and clear
        win_op(1'b0, 2'd0, 1'b0, 2'd2, 32'h0, 4'd3);
        win_op(1'b0, 2'd2, 1'b1, 2'd1, 32'h0000_BEEF, 4'd3);
        reg_wr(32'h00AB_CDEF, 4'd1);
        win_op(1'b0, 2'd3, 1'b1, 2'd0, 32'h0000_0069, 4'd3);
        win_op(1'b0, 2'd1, 1'b0, 2'd0, 32'h0, 4'd9);

        // R4 I/O cycles with 16-bit truncation
        reg_wr(32'hABCD_1232, 4'd1);
        win_op(1'b1, 2'd0, 1'b1, 2'd2, 32'h1122_3344, 4'd8);
        win_op(1'b1, 2'd3, 1'b0, 2'd0, 32'h0, 4'd4);
        reg_wr(32'h0001_FFFE, 4'd1);
        win_op(1'b1, 2'd2, 1'b0, 2'd1, 32'h0, 4'd4);
        win_op(1'b1, 2'd3, 1'b1, 2'd0, 32'h0000_00A5, 4'd4);

        // R5 / R6 illegal size and offset combinations
        bad_op(4'h9, 1'b0, 2'd1, 4'd5);
        bad_op(4'hA, 1'b1, 2'd2, 4'd5);
        bad_op(4'h8, 1'b0, 2'd3, 4'd6);
        bad_op(4'h7, 1'b1, 2'd1, 4'd5);
        bad_op(4'h4, 1'b0, 2'd3, 4'd6);
        // R11 unmapped window
        bad_op(4'hC, 1'b0, 2'd2, 4'd11);
        bad_op(4'hF, 1'b1, 2'd0, 4'd11);

        // R7 collision: next access waits while request stalls
        stall = 3;
        win_op(1'b1, 2'd0, 1'b1, 2'd2, 32'hCAFE_F00D, 4'd7);
        win_op(1'b1, 2'd2, 1'b0, 2'd1, 32'h0, 4'd7);
        wait (q_rsp.size() == 0 && q_dn.size() == 0);
        stall = 0;
        repeat (4) @(negedge clk);
        check(q_rsp.size() == 0 && !dn_valid && cpu_ready, "R8 idle at end",
              {62'h0, dn_valid, cpu_ready}, 64'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule